// File: doc/BRIEF.md
# Fan PWM Drive and Tachometer Monitor

This block drives a cooling fan from one pulse-width-modulated pin and measures the fan's speed on one tachometer pin. Software controls it through a small 32-bit register window at three word-aligned offsets. One register sets the duty and the output mode. One register sets the period divider. One read-only register returns the tachometer pulse count.

The PWM period is a 256-step phase counter. The counter advances once every (divider + 1) system clocks, so one period is 256 × (divider + 1) clocks. New duty and divider values are held back until the current period ends. The output can be inverted, held at its idle level, or driven open-drain through a separate output-enable pin.

The tachometer pin is synchronized and its rising edges are counted over a window of `CLK_HZ` clocks, which is one second at the nominal clock. When each window ends, the count is published and the counter restarts. The register port is control and status, so it has no back-pressure:
- A write completes in the cycle its strobe is seen.
- A read returns data exactly one cycle later, with `rd_valid` set for that cycle.

Top module: `fan_pwm_tach`

## Requirements
- R1: After reset, `pwm_out` is 0, `pwm_oe` is 1, `rd_valid` is 0, and every register reads 0.
- R2: The register at offset 0x0 holds duty in bits 23:16, invert in bit 3, drive-enable in bit 2, open-drain in bit 1 and a free status bit in bit 0. The register at offset 0x4 holds the divider in bits 14:0 and an 11-bit cycle field in bits 25:15. Other bits read 0. Offset 0x8 reads 0 and ignores writes. Read data appears with `rd_valid` one cycle after `rd_en`.
- R3: Bit i of `wstrb` enables byte i of a write, so a write with strobe 4'b0100 changes only the duty field.
- R4: The PWM period is 256 × (divider + 1) clock cycles.
- R5: With drive enabled and invert clear, `pwm_out` is high for duty × (divider + 1) cycles of each period, starting at the start of the period. Duty 0 never goes high.
- R6: A new duty or divider value takes effect only at the next period start. The period that is running completes with the old value.
- R7: With invert set, `pwm_out` is the complement of the non-inverted waveform.
- R8: With drive-enable clear, `pwm_out` stays at the idle level, which equals the invert bit.
- R9: With open-drain set, `pwm_oe` is the complement of `pwm_out`. With open-drain clear, `pwm_oe` is 1.
- R10: The tachometer register at offset 0xC (bits `TACH_W`-1:0) reports the number of `tach_in` rising edges counted in the last complete window of `CLK_HZ` cycles, after a two-flop synchronizer.
- R11: The tachometer count saturates at all ones (0xFFFF at the default width) and does not wrap.
- R12: Writes to offset 0xC are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte enables for writes |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| pwm_out | output | 1 | PWM level |
| pwm_oe | output | 1 | Output enable for the PWM pad |

## Verification
The bench runs the duty extremes 0 and 255 and measures periods at two divider values. A design that stretches the period by one prescaler step, or that leaks a high cycle at duty 0, gives the wrong high-cycle count. It changes duty in the middle of a high phase. A design without period-boundary shadowing drops the output early, and the check taken 100 cycles into that period catches it. It writes with a single-byte strobe and reads back the result, which exposes a design that overwrites the mode bits. It drives tachometer pulse rates both below and above the count capacity. A counter that wraps instead of saturating, or that publishes a partial window, reads back a wrong count.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int DUTY_W = 8;
  localparam int DIV_W  = 15;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_RATE = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_TACH = 4'hC;

  localparam int DUTY_LSB = 16;
  localparam int INV_BIT  = 3;
  localparam int DRV_BIT  = 2;
  localparam int OD_BIT   = 1;

  localparam logic [31:0] MODE_MASK = 32'h00FF_000F;
  localparam logic [31:0] RATE_MASK = 32'h03FF_FFFF;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  div;
    logic              inv;
    logic              drv;
    logic              od;
  } pwm_set_t;
endpackage

// File: rtl/fan_regs.sv
module fan_regs
  import fan_pkg::*;
#(
  parameter int TACH_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic [TACH_W-1:0] tach_val,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output pwm_set_t          set_o
);
  logic [31:0] mode_q, rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rate_q <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wstrb[b]) begin
          if (addr == OFS_MODE) mode_q[8*b +: 8] <= wdata[8*b +: 8] & MODE_MASK[8*b +: 8];
          if (addr == OFS_RATE) rate_q[8*b +: 8] <= wdata[8*b +: 8] & RATE_MASK[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (addr)
          OFS_MODE: rdata <= mode_q;
          OFS_RATE: rdata <= rate_q;
          OFS_TACH: rdata <= 32'(tach_val);
          default:  rdata <= '0;
        endcase
      end
    end
  end

  assign set_o.duty = mode_q[DUTY_LSB +: DUTY_W];
  assign set_o.inv  = mode_q[INV_BIT];
  assign set_o.drv  = mode_q[DRV_BIT];
  assign set_o.od   = mode_q[OD_BIT];
  assign set_o.div  = rate_q[DIV_W-1:0];

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R2
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm
  import fan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pwm_set_t set_i,
  output logic     pwm_out,
  output logic     pwm_oe
);
  logic [DUTY_W-1:0] phase_q, duty_act;
  logic [DIV_W-1:0]  pre_q, div_act;
  logic              step, wrap, raw, lvl;

  assign step = (pre_q == div_act);
  assign wrap = step && (phase_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      pre_q    <= '0;
      duty_act <= '0;
      div_act  <= '0;
    end else begin
      if (step) begin
        pre_q   <= '0;
        phase_q <= phase_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
      if (wrap) begin
        duty_act <= set_i.duty;
        div_act  <= set_i.div;
      end
    end
  end

  assign raw     = (phase_q < duty_act);
  assign lvl     = set_i.drv ? (raw ^ set_i.inv) : set_i.inv;
  assign pwm_out = lvl;
  assign pwm_oe  = set_i.od ? ~lvl : 1'b1;

  AST_DUTY_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act) && $stable(div_act)); // R6
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase_q)); // R4
endmodule

// File: rtl/fan_tick.sv
module fan_tick #(
  parameter int CLK_HZ = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLK_HZ - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/fan_tach.sv
module fan_tach #(
  parameter int TACH_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tach_in,
  input  logic              tick,
  output logic [TACH_W-1:0] count
);
  localparam logic [TACH_W-1:0] FULL = '1;

  logic s0, s1, s2, rise;
  logic [TACH_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s0, s1, s2} <= '0;
    else        {s0, s1, s2} <= {tach_in, s0, s1};
  end

  assign rise = s1 & ~s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      count <= '0;
    end else if (tick) begin
      count <= cnt_q;
      cnt_q <= rise ? TACH_W'(1) : '0;
    end else if (rise && cnt_q != FULL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TACH_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL) && !tick |=> cnt_q == FULL); // R11
  AST_TACH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q <= TACH_W'(1)); // R10
endmodule

// File: rtl/fan_pwm_tach.sv
module fan_pwm_tach
  import fan_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int TACH_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  input  logic [3:0]  wstrb,
  output logic [31:0] rdata,
  output logic        rd_valid,
  input  logic        tach_in,
  output logic        pwm_out,
  output logic        pwm_oe
);
  pwm_set_t          set_w;
  logic              tick_w;
  logic [TACH_W-1:0] tach_w;

  fan_regs #(.TACH_W(TACH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .tach_val(tach_w), .rdata(rdata),
    .rd_valid(rd_valid), .set_o(set_w)
  );

  fan_pwm u_pwm (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  fan_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  fan_tach #(.TACH_W(TACH_W)) u_tach (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .tick(tick_w), .count(tach_w)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !set_w.drv |-> pwm_out == set_w.inv); // R8
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    set_w.od |-> pwm_oe != pwm_out); // R9
  AST_PUSHPULL_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !set_w.od |-> pwm_oe); // R9
endmodule

// File: tb/tb_fan_pwm_tach.sv
module tb_fan_pwm_tach;
  localparam int HZ = 4000;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, tach_in = 0;
  logic [3:0] addr = 0, wstrb = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic rd_valid, pwm_out, pwm_oe;
  int checks = 0, errors = 0, tach_per = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fan_pwm_tach #(.CLK_HZ(HZ), .TACH_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .rd_valid(rd_valid),
    .tach_in(tach_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      if (tach_per != 0) begin
        if (tc >= tach_per - 1) begin tach_in = 1; tc = 0; end
        else begin tach_in = 0; tc++; end
      end else tach_in = 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; wstrb = s;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0; d = rdata; v = rd_valid;
  endtask

  task automatic count_hi(int len, output int hi, output int oe);
    hi = 0; oe = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hi += int'(pwm_out); oe += int'(pwm_oe);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    @(negedge clk); prev = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
  endtask

  function automatic logic [31:0] mode(int duty, bit inv, bit drv, bit od);
    return (32'(duty) << 16) | (32'(inv) << 3) | (32'(drv) << 2) | (32'(od) << 1);
  endfunction

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk("R1 pwm_out", 32'(pwm_out), 0);
    chk("R1 pwm_oe", 32'(pwm_oe), 1);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    rd(4'h0, d, v); chk("R1 mode", d, 0);
    rd(4'h4, d, v); chk("R1 rate", d, 0);
    rd(4'hC, d, v); chk("R1 tach", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d; logic v;
    wr(4'h0, 32'hFFFF_FFFF, 4'hF);
    rd(4'h0, d, v); chk("R2 mode mask", d, 32'h00FF_000F); chk("R2 rd_valid", 32'(v), 1);
    wr(4'h4, 32'hFFFF_FFFF, 4'hF);
    rd(4'h4, d, v); chk("R2 rate mask", d, 32'h03FF_FFFF);
    wr(4'h8, 32'h1234_5678, 4'hF);
    rd(4'h8, d, v); chk("R2 unmapped", d, 0);
    wr(4'h0, 32'h00AA_000F, 4'hF);
    wr(4'h0, 32'h0033_0000, 4'b0100);
    rd(4'h0, d, v); chk("R3 duty-only strobe", d, 32'h0033_000F);
    wr(4'hC, 32'hFFFF_FFFF, 4'hF);
    rd(4'hC, d, v); chk("R12 tach read-only", d, 0);
    wr(4'h4, 0, 4'hF);
    wr(4'h0, 0, 4'hF);
  endtask

  task automatic t_duty(int n, int duty, bit inv, bit od);
    int hi, oe, per;
    per = 256 * (n + 1);
    wr(4'h4, 32'(n), 4'hF);
    wr(4'h0, mode(duty, inv, 1, od), 4'hF);
    repeat (2100) @(negedge clk);
    count_hi(per, hi, oe);
    if (inv) chk("R7 inverted high count", 32'(hi), 32'(per - duty * (n + 1)));
    else     chk("R5 high count", 32'(hi), 32'(duty * (n + 1)));
    if (od)  chk("R9 open-drain oe count", 32'(oe), 32'(per - hi));
    else     chk("R9 push-pull oe count", 32'(oe), 32'(per));
  endtask

  task automatic t_period(int n);
    int c;
    wr(4'h4, 32'(n), 4'hF);
    wr(4'h0, mode(128, 0, 1, 0), 4'hF);
    repeat (2100) @(negedge clk);
    wait_rise();
    c = 0;
    forever begin
      logic prev;
      prev = pwm_out;
      @(negedge clk); c++;
      if (pwm_out && !prev) break;
    end
    chk("R4 period", 32'(c), 32'(256 * (n + 1)));
  endtask

  task automatic t_shadow();
    int hi, oe;
    wr(4'h4, 0, 4'hF);
    wr(4'h0, mode(128, 0, 1, 0), 4'hF);
    repeat (600) @(negedge clk);
    wait_rise();
    wr(4'h0, mode(0, 0, 1, 0), 4'hF);
    repeat (97) @(negedge clk);
    chk("R6 old duty kept mid-period", 32'(pwm_out), 1);
    repeat (200) @(negedge clk);
    count_hi(256, hi, oe);
    chk("R6 new duty after boundary", 32'(hi), 0);
  endtask

  task automatic t_gate();
    int hi, oe;
    wr(4'h0, mode(200, 0, 0, 0), 4'hF);
    count_hi(600, hi, oe);
    chk("R8 idle low", 32'(hi), 0);
    wr(4'h0, mode(200, 1, 0, 1), 4'hF);
    count_hi(600, hi, oe);
    chk("R8 idle high when inverted", 32'(hi), 600);
    chk("R9 oe released at idle high", 32'(oe), 0);
  endtask

  task automatic t_tach(int per, int exp, string req);
    logic [31:0] d; logic v;
    tach_per = per;
    repeat (2 * HZ + 20) @(negedge clk);
    rd(4'hC, d, v);
    chk(req, d, 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_duty(0, 0, 0, 0);
    t_duty(0, 255, 0, 0);
    t_duty(1, 128, 0, 0);
    t_duty(0, 64, 1, 0);
    t_duty(2, 100, 0, 1);
    t_period(0);
    t_period(3);
    t_shadow();
    t_gate();
    t_tach(40, 100, "R10 tach count");
    t_tach(4, 255, "R11 tach saturation");
    t_tach(0, 0, "R10 tach no pulses");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule